// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block sits next to a NAND flash interface and watches every data byte that moves between the host and the flash device. For each 256-byte segment of a page it builds a 22-bit single-error-correcting Hamming code from line parities and column parities. The code of two consecutive segments is kept, so one 512-byte page produces six code bytes. Software compares a stored code with a freshly computed one and does the correction itself. That comparison is outside this block.

A two-bit mode field in the host's control register word drives the engine. The field can clear the engine, let it accumulate, freeze it, or switch the host data-register read path so that it returns code bytes instead of flash data. To arm the engine, software writes clear, then off, then accumulate. Software writes off before it reads out the code and again after. While the mode is off, the code and the byte position are held.

Top module: `nand_hamming_ecc`

## Requirements
- R1: The mode is taken from bits 6:5 of `cfg_wdata` on every cycle with `cfg_we` high. The encodings are 2'b11 clear, 2'b10 readout, 2'b01 accumulate and 2'b00 off. The other bits of the word have no effect. After reset the mode is off.
- R2: While the mode is clear, the byte position returns to zero and both segment codes return to the empty value. In the empty value every code byte reads 0xFF.
- R3: In accumulate mode a byte is counted only on a cycle where `xfer_strobe` is high and both `xfer_cle` and `xfer_ale` are low. Strobes that carry a command or an address change neither the code nor the byte position.
- R4: Let LP(2k) be the parity of the byte parities of all bytes whose in-segment address has bit k clear, and LP(2k+1) the same for bit k set, with k from 0 to 7. CP0, CP1, CP2, CP3, CP4 and CP5 are the parities of data bits {0,2,4,6}, {1,3,5,7}, {0,1,4,5}, {2,3,6,7}, {0..3} and {4..7} over all bytes. Code byte 0 is the inverse of LP7..LP0, with LP0 in bit 0. Code byte 1 is the inverse of LP15..LP8. Code byte 2 is the inverse of CP5..CP0 in bits 7:2, with bits 1:0 set to 1.
- R5: Data bytes 0 to 255 after a clear go to segment 0 and bytes 256 to 511 go to segment 1. Later bytes are ignored until the next clear.
- R6: In off mode, strobes change neither the code nor the byte position. A later return to accumulate continues where the engine left off.
- R7: In readout mode `host_rdata` shows the current code byte. Each `host_rd` moves on to the next byte in the order segment 0 byte 1, byte 0, byte 2, then segment 1 byte 1, byte 0, byte 2. After the sixth byte the order starts again. Entering readout mode restarts the order.
- R8: In every mode other than readout, `host_rdata` equals `flash_rdata`.
- R9: A segment of 256 bytes of 0xFF gives the code bytes 0xFF, 0xFF, 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Host write of the control register word |
| cfg_wdata | input | 8 | Control word; bits 6:5 are the mode |
| xfer_strobe | input | 1 | One cycle per completed data strobe on the flash bus |
| xfer_cle | input | 1 | Command latch level during the strobe |
| xfer_ale | input | 1 | Address latch level during the strobe |
| xfer_data | input | 8 | Byte carried by the strobe |
| host_rd | input | 1 | Host read of the data register |
| flash_rdata | input | 8 | Byte coming back from the flash |
| host_rdata | output | 8 | Data register read value seen by the host |

## Verification
Several data patterns are used, and each one separates a different kind of fault. Erased pages show whether the inversion and the forced low bits are right. Ramp and XOR-scrambled data put every line-parity and column-parity term into play. A single set bit in an otherwise zero segment shows whether a line parity has been assigned to the wrong address bit or a column parity to the wrong data bit. Command and address strobes mixed into the data, bytes sent while the mode is off, and pages longer than two segments show whether the counting gate, the hold and the segment split work. A seventh readout byte tests the swapped order and the wrap-around.

// File: rtl/nhe_pkg.sv
package nhe_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_READ = 2'b10,
    MODE_CLR  = 2'b11
  } ecc_mode_e;

  localparam int MODE_LSB   = 5;
  localparam int LINE_AW    = 8;
  localparam int SEG_BYTES  = 1 << LINE_AW;
  localparam int CODE_BYTES = 3;

  typedef struct packed {
    logic [2*LINE_AW-1:0] lp;
    logic [5:0]           cp;
  } par_t;

  // column parities of one byte
  function automatic logic [5:0] col_par(input logic [7:0] d);
    logic [5:0] c;
    c[0] = ^(d & 8'h55);
    c[1] = ^(d & 8'hAA);
    c[2] = ^(d & 8'h33);
    c[3] = ^(d & 8'hCC);
    c[4] = ^(d & 8'h0F);
    c[5] = ^(d & 8'hF0);
    return c;
  endfunction

  // which line parity terms a byte of parity p at address a toggles
  function automatic logic [2*LINE_AW-1:0] line_mask(input logic [LINE_AW-1:0] a,
                                                     input logic p);
    logic [2*LINE_AW-1:0] m;
    for (int k = 0; k < LINE_AW; k++) begin
      m[2*k+1] = p & a[k];
      m[2*k]   = p & ~a[k];
    end
    return m;
  endfunction

  function automatic par_t par_step(input par_t s, input logic [LINE_AW-1:0] a,
                                    input logic [7:0] d);
    par_t n;
    n.lp = s.lp ^ line_mask(a, ^d);
    n.cp = s.cp ^ col_par(d);
    return n;
  endfunction

  // {byte2, byte1, byte0}, inverted so that an erased segment reads all ones
  function automatic logic [23:0] par_pack(input par_t s);
    return {~s.cp, 2'b11, ~s.lp[15:8], ~s.lp[7:0]};
  endfunction

endpackage

// File: rtl/nhe_mode_ctl.sv
module nhe_mode_ctl
  import nhe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  logic [7:0] cfg_wdata,
  output ecc_mode_e mode,
  output logic      read_entry
);
  ecc_mode_e new_mode;

  assign new_mode   = ecc_mode_e'(cfg_wdata[MODE_LSB +: 2]);
  assign read_entry = cfg_we && (new_mode == MODE_READ) && (mode != MODE_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode <= MODE_OFF;
    else if (cfg_we) mode <= new_mode;
  end
endmodule

// File: rtl/nhe_byte_ctr.sv
module nhe_byte_ctr #(
  parameter int TOTAL = 512,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  assign full = (cnt == CNT_W'(TOTAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (inc && !full) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nhe_seg_acc.sv
module nhe_seg_acc
  import nhe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [LINE_AW-1:0] addr,
  input  logic [7:0]         data,
  output logic [23:0]        code
);
  par_t par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   par_q <= '0;
    else if (clr) par_q <= '0;
    else if (en)  par_q <= par_step(par_q, addr, data);
  end

  assign code = par_pack(par_q);
endmodule

// File: rtl/nhe_rd_sel.sv
module nhe_rd_sel
  import nhe_pkg::*;
#(
  parameter int NUM_SEGS = 2,
  localparam int SEG_W  = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
  localparam int CODE_W = NUM_SEGS * 8 * CODE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic [CODE_W-1:0] code_flat,
  output logic [7:0]        code_byte,
  output logic [1:0]        rd_pos,
  output logic [SEG_W-1:0]  rd_seg
);
  logic [1:0] byte_sel;

  // per segment: second byte, first byte, third byte
  always_comb begin
    case (rd_pos)
      2'd0:    byte_sel = 2'd1;
      2'd1:    byte_sel = 2'd0;
      default: byte_sel = 2'd2;
    endcase
  end

  assign code_byte = code_flat[(int'(rd_seg) * CODE_BYTES + int'(byte_sel)) * 8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos <= '0;
      rd_seg <= '0;
    end else if (restart) begin
      rd_pos <= '0;
      rd_seg <= '0;
    end else if (adv) begin
      if (rd_pos == 2'd2) begin
        rd_pos <= '0;
        rd_seg <= (int'(rd_seg) == NUM_SEGS - 1) ? '0 : rd_seg + 1'b1;
      end else begin
        rd_pos <= rd_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nhe_pkg::*;
#(
  parameter int NUM_SEGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       xfer_strobe,
  input  logic       xfer_cle,
  input  logic       xfer_ale,
  input  logic [7:0] xfer_data,
  input  logic       host_rd,
  input  logic [7:0] flash_rdata,
  output logic [7:0] host_rdata
);
  localparam int TOTAL  = NUM_SEGS * SEG_BYTES;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam int CODE_W = NUM_SEGS * 8 * CODE_BYTES;
  localparam int SEG_W  = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;

  ecc_mode_e          mode;
  logic               read_entry;
  logic               clr_all;
  logic               data_beat;
  logic               acc_fire;
  logic               rd_adv;
  logic               cnt_full;
  logic [CNT_W-1:0]   byte_cnt;
  logic [CNT_W-LINE_AW-1:0] seg_idx;
  logic [LINE_AW-1:0] line_addr;
  logic [CODE_W-1:0]  code_flat;
  logic [7:0]         code_byte;
  logic [1:0]         rd_pos;
  logic [SEG_W-1:0]   rd_seg;

  nhe_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode(mode), .read_entry(read_entry)
  );

  assign clr_all   = (mode == MODE_CLR);
  assign data_beat = xfer_strobe && !xfer_cle && !xfer_ale;
  assign acc_fire  = (mode == MODE_ACC) && data_beat && !cnt_full;
  assign rd_adv    = host_rd && (mode == MODE_READ) && !read_entry;

  nhe_byte_ctr #(.TOTAL(TOTAL)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .inc(acc_fire),
    .cnt(byte_cnt), .full(cnt_full)
  );

  assign seg_idx   = byte_cnt[CNT_W-1:LINE_AW];
  assign line_addr = byte_cnt[LINE_AW-1:0];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic seg_en;
    assign seg_en = acc_fire && (int'(seg_idx) == g);
    nhe_seg_acc u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .en(seg_en),
      .addr(line_addr), .data(xfer_data),
      .code(code_flat[g*8*CODE_BYTES +: 8*CODE_BYTES])
    );
  end

  nhe_rd_sel #(.NUM_SEGS(NUM_SEGS)) u_rd (
    .clk(clk), .rst_n(rst_n), .restart(read_entry), .adv(rd_adv),
    .code_flat(code_flat), .code_byte(code_byte), .rd_pos(rd_pos), .rd_seg(rd_seg)
  );

  assign host_rdata = (mode == MODE_READ) ? code_byte : flash_rdata;
endmodule

// File: rtl/nhe_chk.sv
module nhe_chk
  import nhe_pkg::*;
#(
  parameter int NUM_SEGS = 2,
  localparam int TOTAL  = NUM_SEGS * SEG_BYTES,
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int CODE_W = NUM_SEGS * 8 * CODE_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_wdata,
  input logic              xfer_cle,
  input logic              xfer_ale,
  input logic [7:0]        flash_rdata,
  input logic [7:0]        host_rdata,
  input ecc_mode_e         mode,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [CODE_W-1:0] code_flat,
  input logic [1:0]        rd_pos
);
  // R1
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> mode == $past(cfg_wdata[6:5]));
  // R2
  clr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_CLR |=> byte_cnt == '0);
  // R2
  clr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_CLR |=> code_flat == {CODE_W{1'b1}});
  // R3
  ctl_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_cle || xfer_ale) && mode != MODE_CLR |=> byte_cnt == $past(byte_cnt));
  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_OFF |=> $stable(byte_cnt) && $stable(code_flat));
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(TOTAL));
  // R7
  rd_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pos < 2'd3);
  // R8
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != MODE_READ |-> host_rdata == flash_rdata);
endmodule

bind nand_hamming_ecc nhe_chk #(.NUM_SEGS(NUM_SEGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .xfer_cle(xfer_cle), .xfer_ale(xfer_ale), .flash_rdata(flash_rdata),
  .host_rdata(host_rdata), .mode(mode), .byte_cnt(byte_cnt),
  .code_flat(code_flat), .rd_pos(rd_pos)
);

// File: tb/sim_nand_hamming_ecc.sv
`timescale 1ns/1ps
module sim_nand_hamming_ecc;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic       xfer_strobe = 0, xfer_cle = 0, xfer_ale = 0;
  logic [7:0] xfer_data = 0;
  logic       host_rd = 0;
  logic [7:0] flash_rdata = 8'h3C;
  logic [7:0] host_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_hamming_ecc u0 (.*);

  // ---------------- reference model ----------------
  logic [7:0] q0[$];
  logic [7:0] q1[$];
  int m_mode = 0, m_cnt = 0, m_seg = 0, m_pos = 0;

  function automatic int order_of(int pos);
    return (pos == 0) ? 1 : (pos == 1) ? 0 : 2;
  endfunction

  function automatic logic [7:0] ref_byte(int seg, int which);
    int lp[16];
    int cp[6];
    logic [7:0] d;
    int n;
    logic [7:0] r;
    for (int i = 0; i < 16; i++) lp[i] = 0;
    for (int i = 0; i < 6; i++) cp[i] = 0;
    n = (seg == 0) ? q0.size() : q1.size();
    for (int i = 0; i < n; i++) begin
      int rp = 0;
      d = (seg == 0) ? q0[i] : q1[i];
      for (int b = 0; b < 8; b++) if (d[b]) begin
        rp ^= 1;
        if (b % 2 == 0) cp[0] ^= 1; else cp[1] ^= 1;
        if ((b / 2) % 2 == 0) cp[2] ^= 1; else cp[3] ^= 1;
        if (b < 4) cp[4] ^= 1; else cp[5] ^= 1;
      end
      for (int k = 0; k < 8; k++)
        if ((i >> k) & 1) lp[2*k+1] ^= rp; else lp[2*k] ^= rp;
    end
    r = 8'h00;
    for (int b = 0; b < 8; b++) begin
      if (which == 0) r[b] = (lp[b] == 0);
      else if (which == 1) r[b] = (lp[8+b] == 0);
      else r[b] = (b < 2) ? 1'b1 : (cp[b-2] == 0);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_seg = 0; m_pos = 0;
      q0.delete(); q1.delete();
    end else begin
      if (m_mode == 3) begin
        q0.delete(); q1.delete(); m_cnt = 0;
      end
      if (m_mode == 1 && xfer_strobe && !xfer_cle && !xfer_ale && m_cnt < 512) begin
        if (m_cnt < 256) q0.push_back(xfer_data); else q1.push_back(xfer_data);
        m_cnt++;
      end
      if (cfg_we && cfg_wdata[6:5] == 2'b10 && m_mode != 2) begin
        m_seg = 0; m_pos = 0;
      end else if (m_mode == 2 && host_rd) begin
        m_pos++;
        if (m_pos == 3) begin m_pos = 0; m_seg = (m_seg + 1) % 2; end
      end
      if (cfg_we) m_mode = int'(cfg_wdata[6:5]);
    end
  end

  // per-clock comparison of the read path
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e;
      e = (m_mode == 2) ? ref_byte(m_seg, order_of(m_pos)) : flash_rdata;
      checks++;
      if (host_rdata !== e) begin
        failures++;
        $display("FAIL %s clock compare: got %h expected %h",
                 (m_mode == 2) ? "R7" : "R8", host_rdata, e);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] m, logic [7:0] other);
    @(posedge clk); #1;
    cfg_we = 1; cfg_wdata = (other & 8'h9F) | {1'b0, m, 5'b0};
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic arm();
    set_mode(2'b11, 8'h90);
    set_mode(2'b00, 8'h13);
    set_mode(2'b01, 8'h80);
  endtask

  task automatic send(logic [7:0] d, logic c, logic a);
    @(posedge clk); #1;
    xfer_strobe = 1; xfer_data = d; xfer_cle = c; xfer_ale = a;
    @(posedge clk); #1;
    xfer_strobe = 0; xfer_cle = 0; xfer_ale = 0;
  endtask

  // readout of n bytes, expectations from position alone
  task automatic read_code(string req, int n);
    set_mode(2'b00, 8'h00);
    set_mode(2'b10, 8'h00);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      chk(req, host_rdata, ref_byte((j / 3) % 2, order_of(j % 3)));
      @(posedge clk); #1; host_rd = 1;
      @(posedge clk); #1; host_rd = 0;
    end
    set_mode(2'b00, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state: off mode, passthrough
    @(negedge clk); chk("R1 reset passthrough", host_rdata, 8'h3C);
    // R1/R2 readout straight after reset: empty code
    read_code("R2 empty after reset", 6);

    // R9 erased page, both segments
    arm();
    for (int i = 0; i < 512; i++) send(8'hFF, 0, 0);
    read_code("R9 erased page", 6);
    @(negedge clk);
    chk("R9 byte literal", ref_byte(0, 0), 8'hFF);

    // R4/R5 ramp into seg0, scrambled into seg1
    arm();
    for (int i = 0; i < 256; i++) send(8'(i * 7 + 3), 0, 0);
    for (int i = 0; i < 100; i++) send(8'(i) ^ 8'h5A, 0, 0);
    read_code("R4 R5 ramp/scramble", 6);

    // R4 single set bit at address 77, with R3 control strobes mixed in
    arm();
    for (int i = 0; i < 200; i++) begin
      if (i % 37 == 5) send(8'hFF, 1, 0);
      if (i % 41 == 9) send(8'hA5, 0, 1);
      send((i == 77) ? 8'h04 : 8'h00, 0, 0);
    end
    // R6 strobes while off are ignored, then accumulate resumes
    set_mode(2'b00, 8'h00);
    for (int i = 0; i < 20; i++) send(8'hC3, 0, 0);
    set_mode(2'b01, 8'h00);
    for (int i = 0; i < 60; i++) send(8'(i) | 8'h01, 0, 0);
    // R7 seven reads: wrap to the first byte
    read_code("R3 R6 R7 single bit / wrap", 7);

    // R5 more than 512 bytes: extra ignored
    arm();
    for (int i = 0; i < 600; i++) send(8'(i * 13), 0, 0);
    read_code("R5 overflow ignored", 6);

    // R2 clear after data: empty code
    arm();
    read_code("R2 clear after data", 6);

    // R8 passthrough in off and accumulate modes
    for (int i = 0; i < 4; i++) begin
      flash_rdata = 8'(8'h11 * (i + 1));
      @(negedge clk); chk("R8 off passthrough", host_rdata, flash_rdata);
    end
    set_mode(2'b01, 8'h00);
    flash_rdata = 8'hE7;
    @(negedge clk); chk("R8 accumulate passthrough", host_rdata, 8'hE7);
    set_mode(2'b00, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule